// File: doc/BRIEF.md
# Receive Character Queue with Status-Word Reads

This block buffers received characters for one serial channel. A bit-level deserializer hands it one byte at a time, together with break, framing-error and parity-error flags and a one-cycle valid strobe. Each accepted character is stored with a 4-bit per-character status. The queue holds up to `DEPTH` characters, 1023 by default, and its fill level is always visible.

The host reads the queue through a 16-bit data view. In normal mode one read returns two data bytes. In status mode one read returns a data byte together with that character's status byte. A separate 16-bit status word holds these items:
- the mode bit;
- sticky event flags that clear when the word is read;
- a data-available bit;
- the levels of three modem inputs.

A selectable trigger flag rises when the fill level reaches one of four quantised thresholds. Two programmable compare bytes watch the incoming stream.

Both views are combinational. A read strobe (`data_rd` or `stat_rd`) takes effect on the clock edge where it is sampled: the data view then advances, and the sticky flags are cleared.

Top module: `rx_char_fifo`

## Requirements
- R1: Each stored character raises `fill_cnt` by one and each consumed entry lowers it by one. `fill_cnt` never exceeds `DEPTH`. After reset it is 0.
- R2: In status mode (`stat_rdata[15]`=1), `data_rdata[7:0]` is the oldest character and `data_rdata[15:8]` is `{4'b0, brk, frm, ovr, par}`, with break at bit 11, framing at bit 10, overrun at bit 9 and parity at bit 8. A `data_rd` consumes exactly one entry.
- R3: In normal mode, `data_rdata[7:0]` is the oldest character and `data_rdata[15:8]` is the next one. A `data_rd` consumes two entries. When only one entry is held, the high byte reads 0 and the read consumes one entry.
- R4: With the queue empty, `data_rdata` reads 0, and a `data_rd` changes neither the count nor the stored order.
- R5: A write to the status word (`stat_wr`) loads bit 15 of `stat_wdata` as the mode, which reads back in `stat_rdata[15]`. All other written bits have no effect. After reset the block is in normal mode.
- R6: `trig_sel` picks the trigger threshold. 00 never triggers. 01 triggers at 1 character or more. 10 triggers at (`DEPTH`+1)/2 or more. 11 triggers at 7·(`DEPTH`+1)/8 or more.
- R7: A character arriving while `DEPTH` entries are held is discarded, and the stored contents are kept. This sets sticky overflow (`stat_rdata[13]`) and marks the overrun bit in the status of the next character that is stored.
- R8: An accepted character equal to compare byte 2 or compare byte 1 sets sticky bit 12 or bit 11 respectively, but only while that compare is enabled.
- R9: Sticky bits 10, 9 and 8 collect the break, framing and parity flags of accepted characters. A `stat_rd` clears bits 13 to 8. An event in the same cycle as the clear remains set.
- R10: The low status byte shows data available (count ≠ 0) at bit 0, and `cts`, `dsr` and `cd` at bits 5, 4 and 3. Bits 14, 7, 6, 2 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Character strobe from the deserializer |
| rx_byte | input | 8 | Received character |
| rx_brk | input | 1 | Break detected on this character |
| rx_frm | input | 1 | Framing error on this character |
| rx_par | input | 1 | Parity error on this character |
| cmp1_en | input | 1 | Enable compare byte 1 |
| cmp1_val | input | 8 | Compare byte 1 |
| cmp2_en | input | 1 | Enable compare byte 2 |
| cmp2_val | input | 8 | Compare byte 2 |
| trig_sel | input | 2 | Trigger threshold select |
| cts | input | 1 | CTS modem input level |
| dsr | input | 1 | DSR modem input level |
| cd | input | 1 | CD modem input level |
| stat_wr | input | 1 | Status-word write strobe |
| stat_wdata | input | 16 | Status-word write data (bit 15 = mode) |
| stat_rd | input | 1 | Status-word read strobe (clears sticky bits) |
| stat_rdata | output | 16 | Status word |
| data_rd | input | 1 | Data read strobe (consumes entries) |
| data_rdata | output | 16 | Data word at the head of the queue |
| fill_cnt | output | $clog2(DEPTH+1) | Number of stored characters |
| trig_hit | output | 1 | Fill level at or above the selected threshold |

## Verification
The bench uses a 15-entry queue. It drives the queue past full so that discarded characters are exercised. A design that overwrote the oldest entry, or advanced its write pointer on a drop, would return the wrong bytes later. A design that forgot the pending overrun would store the next character with a clear overrun bit. The bench reads out an odd count in normal mode to catch a two-entry pop when only one entry is held, which would underflow the count. It also issues a status read together with an error character, and a data read on an empty queue. After every cycle it sweeps all four trigger selections to pin each threshold to its exact count, so an off-by-one threshold shows up.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_ONE  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_7_8  = 2'b11
  } trig_lvl_e;

  // status word bit positions
  localparam int ST_MODE  = 15;
  localparam int ST_OVF   = 13;
  localparam int ST_AVAIL = 0;

  typedef struct packed {
    logic brk;
    logic frm;
    logic ovr;
    logic par;
  } chr_stat_t;

  typedef struct packed {
    chr_stat_t  st;
    logic [7:0] data;
  } fifo_ent_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 1023,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  fifo_ent_t     ent_i,
  input  logic          pop_i,
  input  logic          pair_i,
  output logic          accept_o,
  output logic [CW-1:0] cnt_o,
  output fifo_ent_t     head0_o,
  output fifo_ent_t     head1_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d, rp_nx;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    pop_n;
  fifo_ent_t     mem_q [DEPTH];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign accept_o = push_i && (cnt_q != CW'(DEPTH));

  always_comb begin
    pop_n = 2'd0;
    if (pop_i && (cnt_q != '0)) begin
      pop_n = (pair_i && (cnt_q >= CW'(2))) ? 2'd2 : 2'd1;
    end
  end

  always_comb begin
    rp_nx = bump(rp_q);
    case (pop_n)
      2'd1:    rp_d = rp_nx;
      2'd2:    rp_d = bump(rp_nx);
      default: rp_d = rp_q;
    endcase
    wp_d  = accept_o ? bump(wp_q) : wp_q;
    cnt_d = cnt_q + CW'(accept_o) - CW'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept_o) begin
      mem_q[wp_q] <= ent_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign head0_o = mem_q[rp_q];
  assign head1_o = mem_q[rp_nx];

  p_cnt_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && push_i && !pop_i) |=> (cnt_q == CW'(DEPTH)) && $stable(wp_q));

  p_pair_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && pair_i && cnt_q >= CW'(2) && !push_i) |=> cnt_q == $past(cnt_q) - CW'(2));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q == '0 && !push_i) |=> (cnt_q == '0) && $stable(rp_q));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  logic       accept_i,
  input  logic [7:0] data_i,
  input  logic       brk_i,
  input  logic       frm_i,
  input  logic       par_i,
  input  logic       cmp1_en_i,
  input  logic [7:0] cmp1_val_i,
  input  logic       cmp2_en_i,
  input  logic [7:0] cmp2_val_i,
  input  logic       clr_i,
  input  logic       mode_wr_i,
  input  logic       mode_val_i,
  output logic       mode_o,
  output logic [5:0] sticky_o,
  output logic       ovr_mark_o
);

  logic [5:0] sticky_q, sticky_d, set_vec;
  logic       drop_q, drop_d, mode_q, mode_d;
  logic       hit1, hit2, dropped;

  assign hit1    = cmp1_en_i && (data_i == cmp1_val_i);
  assign hit2    = cmp2_en_i && (data_i == cmp2_val_i);
  assign dropped = push_i && !accept_i;

  always_comb begin
    // order: overflow, match2, match1, break, framing, parity
    set_vec  = {dropped, accept_i & hit2, accept_i & hit1,
                accept_i & brk_i, accept_i & frm_i, accept_i & par_i};
    sticky_d = (clr_i ? 6'd0 : sticky_q) | set_vec;
    if (dropped) begin
      drop_d = 1'b1;
    end else if (accept_i) begin
      drop_d = 1'b0;
    end else begin
      drop_d = drop_q;
    end
    mode_d = mode_wr_i ? mode_val_i : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      drop_q   <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      drop_q   <= drop_d;
      mode_q   <= mode_d;
    end
  end

  assign sticky_o   = sticky_q;
  assign ovr_mark_o = drop_q;
  assign mode_o     = mode_q;

  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !accept_i) |=> sticky_q[5] && drop_q);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !push_i) |=> sticky_q == 6'd0);

  p_mode_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> mode_q == $past(mode_val_i));

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
  import rxq_pkg::*;
#(
  parameter int DEPTH = 1023,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  trig_lvl_e     sel_i,
  input  logic [CW-1:0] cnt_i,
  output logic          hit_o
);

  localparam int HALF_LVL  = (DEPTH + 1) / 2;
  localparam int SEVEN_LVL = ((DEPTH + 1) * 7) / 8;

  always_comb begin
    case (sel_i)
      TRIG_ONE:  hit_o = (cnt_i != '0);
      TRIG_HALF: hit_o = (cnt_i >= CW'(HALF_LVL));
      TRIG_7_8:  hit_o = (cnt_i >= CW'(SEVEN_LVL));
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 1023,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_brk,
  input  logic          rx_frm,
  input  logic          rx_par,
  input  logic          cmp1_en,
  input  logic [7:0]    cmp1_val,
  input  logic          cmp2_en,
  input  logic [7:0]    cmp2_val,
  input  logic [1:0]    trig_sel,
  input  logic          cts,
  input  logic          dsr,
  input  logic          cd,
  input  logic          stat_wr,
  input  logic [15:0]   stat_wdata,
  input  logic          stat_rd,
  output logic [15:0]   stat_rdata,
  input  logic          data_rd,
  output logic [15:0]   data_rdata,
  output logic [CW-1:0] fill_cnt,
  output logic          trig_hit
);

  logic      accept, mode, ovr_mark;
  logic [5:0] sticky;
  fifo_ent_t ent_in, head0, head1;

  always_comb begin
    ent_in.data   = rx_byte;
    ent_in.st.brk = rx_brk;
    ent_in.st.frm = rx_frm;
    ent_in.st.ovr = ovr_mark;
    ent_in.st.par = rx_par;
  end

  rxq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (rx_valid),
    .ent_i    (ent_in),
    .pop_i    (data_rd),
    .pair_i   (!mode),
    .accept_o (accept),
    .cnt_o    (fill_cnt),
    .head0_o  (head0),
    .head1_o  (head1)
  );

  rxq_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (rx_valid),
    .accept_i   (accept),
    .data_i     (rx_byte),
    .brk_i      (rx_brk),
    .frm_i      (rx_frm),
    .par_i      (rx_par),
    .cmp1_en_i  (cmp1_en),
    .cmp1_val_i (cmp1_val),
    .cmp2_en_i  (cmp2_en),
    .cmp2_val_i (cmp2_val),
    .clr_i      (stat_rd),
    .mode_wr_i  (stat_wr),
    .mode_val_i (stat_wdata[ST_MODE]),
    .mode_o     (mode),
    .sticky_o   (sticky),
    .ovr_mark_o (ovr_mark)
  );

  rxq_trigger #(.DEPTH(DEPTH), .CW(CW)) u_trig (
    .sel_i (trig_lvl_e'(trig_sel)),
    .cnt_i (fill_cnt),
    .hit_o (trig_hit)
  );

  always_comb begin
    if (fill_cnt == '0) begin
      data_rdata = 16'h0000;
    end else if (mode) begin
      data_rdata = {4'b0000, head0.st, head0.data};
    end else begin
      data_rdata = {(fill_cnt >= CW'(2)) ? head1.data : 8'h00, head0.data};
    end
    stat_rdata = {mode, 1'b0, sticky, 2'b00, cts, dsr, cd, 2'b00, fill_cnt != '0};
  end

  p_trig_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == 2'b00) |-> !trig_hit);

  p_empty_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == '0) |-> (data_rdata == 16'h0000) && !stat_rdata[ST_AVAIL]);

endmodule

// File: tb/rx_char_fifo_bench.sv
`timescale 1ns/1ps
module rx_char_fifo_bench;

  localparam int DEPTH = 15;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rx_brk, rx_frm, rx_par;
  logic [7:0] rx_byte;
  logic cmp1_en, cmp2_en;
  logic [7:0] cmp1_val, cmp2_val;
  logic [1:0] trig_sel;
  logic cts, dsr, cd;
  logic stat_wr, stat_rd, data_rd;
  logic [15:0] stat_wdata, stat_rdata, data_rdata;
  logic [CW-1:0] fill_cnt;
  logic trig_hit;

  always #2.5 clk = ~clk;

  rx_char_fifo #(.DEPTH(DEPTH)) u_rx_char_fifo (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_par(rx_par),
    .cmp1_en(cmp1_en), .cmp1_val(cmp1_val), .cmp2_en(cmp2_en), .cmp2_val(cmp2_val),
    .trig_sel(trig_sel), .cts(cts), .dsr(dsr), .cd(cd),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .data_rd(data_rd), .data_rdata(data_rdata), .fill_cnt(fill_cnt), .trig_hit(trig_hit)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic [11:0] q[$];
  logic [5:0]  sticky_m = '0;
  bit          drop_m = 1'b0;
  bit          mode_m = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit trig_exp(input int s, input int n);
    case (s)
      1: return n >= 1;
      2: return n >= (DEPTH + 1) / 2;
      3: return n >= ((DEPTH + 1) * 7) / 8;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_all();
    logic [15:0] ed;
    logic [15:0] es;
    int n = q.size();
    chk("R1 fill count", 32'(fill_cnt), 32'(n));
    if (n == 0) begin
      ed = 16'h0;
    end else if (mode_m) begin
      ed = {4'b0, q[0]};
    end else begin
      ed = {(n >= 2) ? q[1][7:0] : 8'h00, q[0][7:0]};
    end
    chk(n == 0 ? "R4 empty data" : (mode_m ? "R2 status read" : "R3 normal read"),
        32'(data_rdata), 32'(ed));
    es = {mode_m, 1'b0, sticky_m, 2'b00, cts, dsr, cd, 2'b00, n != 0};
    chk("R9 R10 status word", 32'(stat_rdata), 32'(es));
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      #0.1;
      chk("R6 trigger", 32'(trig_hit), 32'(trig_exp(s, n)));
    end
  endtask

  task automatic step(input bit pu, input logic [7:0] b, input bit brk, input bit frm,
                      input bit par, input bit po, input bit sr);
    int n;
    bit acc;
    logic [5:0] setv;
    @(negedge clk);
    rx_valid = pu; rx_byte = b; rx_brk = brk; rx_frm = frm; rx_par = par;
    data_rd = po; stat_rd = sr;
    @(posedge clk);
    #1;
    rx_valid = 1'b0; data_rd = 1'b0; stat_rd = 1'b0;
    n = q.size();
    acc = pu && (n < DEPTH);
    setv = '0;
    if (pu && acc)
      setv = {1'b0, cmp2_en && (b == cmp2_val), cmp1_en && (b == cmp1_val), brk, frm, par};
    else if (pu)
      setv[5] = 1'b1;
    if (po && n > 0) begin
      void'(q.pop_front());
      if (!mode_m && n >= 2) void'(q.pop_front());
    end
    if (acc) begin
      q.push_back({brk, frm, drop_m, par, b});
      drop_m = 1'b0;
    end else if (pu) begin
      drop_m = 1'b1;
    end
    sticky_m = (sr ? 6'd0 : sticky_m) | setv;
    check_all();
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    stat_wr = 1'b1;
    stat_wdata = {m, 15'h7FFF};
    @(posedge clk);
    #1;
    stat_wr = 1'b0;
    mode_m = m;
    chk("R5 mode bit", 32'(stat_rdata[15]), 32'(m));
    check_all();
  endtask

  function automatic logic [7:0] pat(input int i);
    if (i == 3) return 8'h5A;
    if (i == 6) return 8'hA5;
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rx_valid = 0; rx_byte = 0; rx_brk = 0; rx_frm = 0; rx_par = 0;
    cmp1_en = 1; cmp1_val = 8'h5A; cmp2_en = 1; cmp2_val = 8'hA5;
    trig_sel = 0; cts = 1; dsr = 0; cd = 1;
    stat_wr = 0; stat_wdata = 0; stat_rd = 0; data_rd = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // reset state: R1 count 0, R5 normal mode, R10 low byte
    check_all();

    // status mode: fill past capacity (R7 overflow)
    set_mode(1'b1);
    for (int i = 0; i < DEPTH + 2; i++) begin
      step(1'b1, pat(i), (i % 7) == 2, (i % 5) == 3, (i % 4) == 1, 1'b0, 1'b0);
    end
    chk("R7 count held at full", 32'(fill_cnt), 32'(DEPTH));
    chk("R7 overflow sticky", 32'(stat_rdata[13]), 32'd1);
    chk("R8 compare matches", 32'(stat_rdata[12:11]), 32'h3);

    // read-to-clear of the sticky bits (R9)
    cts = 0; dsr = 1; cd = 0;
    step(1'b0, 8'h00, 0, 0, 0, 1'b0, 1'b1);
    chk("R9 sticky cleared", 32'(stat_rdata[13:8]), 32'h0);

    // one read frees a slot; the next stored character carries the overrun mark (R7)
    step(1'b0, 8'h00, 0, 0, 0, 1'b1, 1'b0);
    step(1'b1, 8'h3C, 0, 0, 0, 1'b0, 1'b0);
    chk("R7 overrun marked on stored char", 32'(q[DEPTH-1][9]), 32'd1);

    // drain in status mode, then read when empty (R2, R4)
    for (int i = 0; i < DEPTH + 1; i++) begin
      step(1'b0, 8'h00, 0, 0, 0, 1'b1, 1'b0);
    end
    chk("R4 empty after drain", 32'(fill_cnt), 32'd0);

    // normal mode, odd count, compare 1 disabled (R3, R8)
    set_mode(1'b0);
    step(1'b0, 8'h00, 0, 0, 0, 1'b0, 1'b1);
    cmp1_en = 0;
    for (int i = 0; i < 7; i++) begin
      step(1'b1, pat(i + 1), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    chk("R8 disabled compare ignored", 32'(stat_rdata[11]), 32'd0);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 8'h00, 0, 0, 0, 1'b1, 1'b0);
    end

    // simultaneous error char and status read: the event survives (R9)
    step(1'b1, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9 same-cycle event kept", 32'(stat_rdata[10:8]), 32'h5);

    // push and pop together with one entry held in normal mode (R3)
    step(1'b1, 8'h22, 0, 0, 0, 1'b1, 1'b0);
    step(1'b1, 8'h33, 0, 1'b1, 0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 0, 0, 0, 1'b1, 1'b0);
    step(1'b0, 8'h00, 0, 0, 0, 1'b1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule